// File: doc/BRIEF.md
# Four-Level Address Pin Decoder

This block works out how each of two address-select pins is wired. A pin can be tied low, tied high, tied to the serial clock line or tied to the serial data line. The block learns this by watching each pin against both bus lines during the address byte of every bus transmission. It does this whether or not the transmission is aimed at this device. From the two decoded states it produces three things:

- the four variable slave-address bits that both of the device's slave addresses share;
- one pull-up enable for each group of four inputs;
- the power-up level of each group of four push-pull outputs.

Before the first transmission the bus lines sit high, so a pin wired to either line reads as tied high. The block then classifies each pin from its static level. After an address byte finishes, the new classification is registered and held until the next address byte finishes. The slave-address compare elsewhere therefore always sees one stable value within a transaction. All inputs arrive already synchronized to `clk_i`. The START and STOP strobes come from the bus engine.

Top module: `addr_pin_decoder`

## Requirements
- R1: While reset is asserted, both pins decode as tied high: `addr_var_o` = 4'b1101, `pullup_en_o` = 2'b11, `out_default_o` = 8'hFF.
- R2: Before the first completed address byte, and while no address byte is being observed, each pin is classified from its level alone, one cycle after that level is seen: 1 gives tied high and 0 gives tied low. A pin wired to an idle bus line therefore reads as tied high.
- R3: The observation window opens on the START strobe and closes on the eighth rising SCL edge after it. The new decode is loaded on that edge and is visible on the outputs from the following cycle.
- R4: A pin is classified as following SCL when it equalled SCL at every cycle from the START strobe to the closing edge, and SCL changed at least once in that span. This test takes precedence over the SDA test.
- R5: A pin is classified as following SDA under the same rule applied to SDA.
- R6: A pin that passes neither test takes its static class from its level on the closing edge. This includes a pin wired to SDA when the address byte holds SDA low throughout, which then decodes as tied low.
- R7: A STOP before the eighth edge abandons the window, and the decode keeps its previous value. A repeated START restarts the edge count from zero.
- R8: The outputs do not change while a window is open, up to its closing edge. A new decode is made on every completed address byte, whatever its contents.
- R9: Upper pin code on `addr_var_o[3:2]`: SCL = 00, SDA = 01, low = 10, high = 11.
- R10: Lower pin code on `addr_var_o[1:0]`: low = 00, high = 01, SCL = 10, SDA = 11.
- R11: `pullup_en_o[0]` (inputs 0–3, from the lower pin) and `pullup_en_o[1]` (inputs 4–7, from the upper pin) are 1 unless that pin decodes as tied low.
- R12: `out_default_o[3:0]` (outputs 8–11, from the lower pin) and `out_default_o[7:4]` (outputs 12–15, from the upper pin) are all 0 when that pin decodes as tied low, otherwise all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_hi_i | input | 1 | Synchronized level of the upper address pin |
| pin_lo_i | input | 1 | Synchronized level of the lower address pin |
| scl_i | input | 1 | Synchronized serial clock line |
| sda_i | input | 1 | Synchronized serial data line |
| start_i | input | 1 | One-cycle START or repeated START strobe |
| stop_i | input | 1 | One-cycle STOP strobe |
| addr_var_o | output | 4 | Variable slave-address bits, upper pin in [3:2] |
| pullup_en_o | output | 2 | Pull-up enable per input group of four |
| out_default_o | output | 8 | Power-up level of the eight push-pull outputs |

## Verification
The assertions take two things for granted about the inputs:

- the pins and both bus lines pass through the same synchronizer depth, so a pin wired to a line equals it in every cycle;
- START and STOP are single-cycle strobes that never coincide, with START raised in the cycle where SDA is already low and SCL high.

The stimulus keeps within these by deriving each pin combinationally from the bench's own SCL and SDA registers. All of them change only on the falling clock edge, and each strobe is raised together with the line change that defines it.

// File: rtl/addr_pin_pkg.sv
package addr_pin_pkg;
  // code values match the lower pin field; the upper field flips bit 1
  typedef enum logic [1:0] {
    CONN_GND = 2'd0,
    CONN_SUP = 2'd1,
    CONN_SCL = 2'd2,
    CONN_SDA = 2'd3
  } conn_e;

  localparam int unsigned CODE_W = 2;
endpackage

// File: rtl/addr_window.sv
module addr_window #(
  parameter int unsigned ADDR_CLOCKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic start_i,
  input  logic stop_i,
  output logic obs_o,
  output logic commit_o,
  output logic scl_tog_o,
  output logic sda_tog_o
);
  localparam int unsigned CNT_W = $clog2(ADDR_CLOCKS + 1);

  logic             scl_q, sda_q, in_win_q;
  logic [CNT_W-1:0] cnt_q;
  logic             scl_rise, last_edge;

  assign scl_rise  = scl_i & ~scl_q;
  assign last_edge = (cnt_q == CNT_W'(ADDR_CLOCKS - 1));
  assign commit_o  = in_win_q & scl_rise & last_edge & ~start_i & ~stop_i;
  assign obs_o     = in_win_q;
  assign scl_tog_o = scl_i ^ scl_q;
  assign sda_tog_o = sda_i ^ sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_win_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      in_win_q <= 1'b1;
      cnt_q    <= '0;
    end else if (stop_i) begin
      in_win_q <= 1'b0;
      cnt_q    <= '0;
    end else if (in_win_q && scl_rise) begin
      if (last_edge) begin
        in_win_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_NO_START_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni) !(start_i && stop_i)); // R7
  AST_CNT_BOUND:     assert property (@(posedge clk_i) disable iff (!rst_ni) in_win_q |-> (cnt_q < CNT_W'(ADDR_CLOCKS))); // R3
  AST_START_OPENS:   assert property (@(posedge clk_i) disable iff (!rst_ni) start_i |=> (in_win_q && cnt_q == '0)); // R3
  AST_COMMIT_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni) commit_o |=> !in_win_q); // R3
  AST_STOP_CLOSES:   assert property (@(posedge clk_i) disable iff (!rst_ni) stop_i |=> !in_win_q); // R7
endmodule

// File: rtl/pin_classifier.sv
module pin_classifier
  import addr_pin_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pin_i,
  input  logic  scl_i,
  input  logic  sda_i,
  input  logic  start_i,
  input  logic  obs_i,
  input  logic  commit_i,
  input  logic  scl_tog_i,
  input  logic  sda_tog_i,
  output conn_e conn_o
);
  logic  m_scl_q, m_sda_q, t_scl_q, t_sda_q, seen_q;
  conn_e conn_q, static_c, next_c;
  logic  eq_scl, eq_sda, fin_scl, fin_sda;

  assign eq_scl   = (pin_i == scl_i);
  assign eq_sda   = (pin_i == sda_i);
  // include the closing-edge sample itself
  assign fin_scl  = m_scl_q & eq_scl & (t_scl_q | scl_tog_i);
  assign fin_sda  = m_sda_q & eq_sda & (t_sda_q | sda_tog_i);
  assign static_c = pin_i ? CONN_SUP : CONN_GND;

  always_comb begin
    if (fin_scl)      next_c = CONN_SCL;
    else if (fin_sda) next_c = CONN_SDA;
    else              next_c = static_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_scl_q <= 1'b0;
      m_sda_q <= 1'b0;
      t_scl_q <= 1'b0;
      t_sda_q <= 1'b0;
    end else if (start_i) begin
      m_scl_q <= eq_scl;
      m_sda_q <= eq_sda;
      t_scl_q <= 1'b0;
      t_sda_q <= 1'b0;
    end else if (obs_i) begin
      m_scl_q <= m_scl_q & eq_scl;
      m_sda_q <= m_sda_q & eq_sda;
      t_scl_q <= t_scl_q | scl_tog_i;
      t_sda_q <= t_sda_q | sda_tog_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q <= CONN_SUP;
      seen_q <= 1'b0;
    end else if (commit_i) begin
      conn_q <= next_c;
      seen_q <= 1'b1;
    end else if (!seen_q && !obs_i && !start_i) begin
      conn_q <= static_c;
    end
  end

  assign conn_o = conn_q;

  AST_HOLD_IN_TXN:  assert property (@(posedge clk_i) disable iff (!rst_ni) (obs_i && !commit_i) |=> $stable(conn_q)); // R8
  AST_PRE_STATIC:   assert property (@(posedge clk_i) disable iff (!rst_ni) (!seen_q && !obs_i && !start_i) |=> (conn_q == CONN_GND || conn_q == CONN_SUP)); // R2
  AST_SCL_MATCHED:  assert property (@(posedge clk_i) disable iff (!rst_ni) (commit_i && !eq_scl) |=> (conn_q != CONN_SCL)); // R4
  AST_SDA_MATCHED:  assert property (@(posedge clk_i) disable iff (!rst_ni) (commit_i && !eq_sda) |=> (conn_q != CONN_SDA)); // R5
endmodule

// File: rtl/pin_encoder.sv
module pin_encoder
  import addr_pin_pkg::*;
#(
  parameter bit          FLIP    = 1'b0,
  parameter int unsigned GROUP_W = 4
) (
  input  conn_e              conn_i,
  output logic [CODE_W-1:0]  code_o,
  output logic               pullup_o,
  output logic [GROUP_W-1:0] default_o
);
  logic not_gnd;

  assign not_gnd   = (conn_i != CONN_GND);
  assign code_o    = conn_i ^ {FLIP, 1'b0};
  assign pullup_o  = not_gnd;
  assign default_o = {GROUP_W{not_gnd}};
endmodule

// File: rtl/addr_pin_decoder.sv
module addr_pin_decoder
  import addr_pin_pkg::*;
#(
  parameter int unsigned ADDR_CLOCKS = 8,
  parameter int unsigned GROUP_W     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pin_hi_i,
  input  logic                 pin_lo_i,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  output logic [3:0]           addr_var_o,
  output logic [1:0]           pullup_en_o,
  output logic [2*GROUP_W-1:0] out_default_o
);
  localparam int unsigned NUM_PINS = 2;

  logic                obs, commit, scl_tog, sda_tog;
  logic [NUM_PINS-1:0] pins;

  assign pins = {pin_hi_i, pin_lo_i};

  addr_window #(.ADDR_CLOCKS(ADDR_CLOCKS)) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .obs_o     (obs),
    .commit_o  (commit),
    .scl_tog_o (scl_tog),
    .sda_tog_o (sda_tog)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    conn_e conn;

    pin_classifier u_cls (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (pins[g]),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .start_i   (start_i),
      .obs_i     (obs),
      .commit_i  (commit),
      .scl_tog_i (scl_tog),
      .sda_tog_i (sda_tog),
      .conn_o    (conn)
    );

    pin_encoder #(.FLIP(g == 1), .GROUP_W(GROUP_W)) u_enc (
      .conn_i    (conn),
      .code_o    (addr_var_o[g*CODE_W +: CODE_W]),
      .pullup_o  (pullup_en_o[g]),
      .default_o (out_default_o[g*GROUP_W +: GROUP_W])
    );
  end

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (obs && !commit) |=> $stable(addr_var_o)); // R8
endmodule

// File: tb/addr_pin_decoder_test.sv
module addr_pin_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1, start_p = 1'b0, stop_p = 1'b0;
  logic [1:0] conn_hi = 2'd2, conn_lo = 2'd0; // 0 low, 1 high, 2 SCL, 3 SDA
  logic       pin_hi, pin_lo;
  logic [3:0] addr;
  logic [1:0] pu;
  logic [7:0] dflt;
  int         total = 0, bad = 0;
  bit         done = 1'b0;
  logic [3:0] prev;

  always #10 clk = ~clk;

  function automatic logic drive_pin(logic [1:0] c, logic s, logic d);
    case (c)
      2'd0:    return 1'b0;
      2'd1:    return 1'b1;
      2'd2:    return s;
      default: return d;
    endcase
  endfunction

  assign pin_hi = drive_pin(conn_hi, scl, sda);
  assign pin_lo = drive_pin(conn_lo, scl, sda);

  addr_pin_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .pin_hi_i(pin_hi), .pin_lo_i(pin_lo),
    .scl_i(scl), .sda_i(sda), .start_i(start_p), .stop_i(stop_p),
    .addr_var_o(addr), .pullup_en_o(pu), .out_default_o(dflt)
  );

  // {hi, lo, address byte, expected addr_var}
  localparam logic [15:0] VEC [10] = '{
    16'h0A58, 16'h5A5D, 16'hBA53, 16'hED36, 16'hA402,
    16'hF557, 16'h1229, 16'h700C, 16'hCFF4, 16'h680E
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [3:0] exp);
    logic [1:0] epu;
    logic [7:0] edf;
    epu = {exp[3:2] != 2'b10, exp[1:0] != 2'b00};
    edf = {{4{epu[1]}}, {4{epu[0]}}};
    total++;
    if (addr !== exp) begin
      bad++;
      $display("FAIL %s R9/R10 addr actual=%b expected=%b", tag, addr, exp);
    end
    total++;
    if (pu !== epu) begin
      bad++;
      $display("FAIL %s R11 pullup actual=%b expected=%b", tag, pu, epu);
    end
    total++;
    if (dflt !== edf) begin
      bad++;
      $display("FAIL %s R12 default actual=%h expected=%h", tag, dflt, edf);
    end
  endtask

  task automatic do_start();
    sda = 1'b0; start_p = 1'b1; step(1);
    start_p = 1'b0; step(1);
  endtask

  task automatic do_bit(input logic b);
    scl = 1'b0; step(1);
    sda = b;    step(1);
    scl = 1'b1; step(2);
  endtask

  task automatic do_stop();
    scl = 1'b0; step(1);
    sda = 1'b0; step(1);
    scl = 1'b1; step(1);
    sda = 1'b1; stop_p = 1'b1; step(1);
    stop_p = 1'b0; step(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R1 reset value", 4'b1101);
    rst_n = 1'b1;
    step(2);
    check("R2 static after reset, SCL pin idle high", 4'b1100);
    conn_lo = 2'd3; step(2);
    check("R2 SDA pin idle high", 4'b1101);
    conn_hi = 2'd0; conn_lo = 2'd0; step(2);
    check("R2 both tied low", 4'b1000);
    prev = 4'b1000;

    for (int v = 0; v < 10; v++) begin
      conn_hi = VEC[v][15:14];
      conn_lo = VEC[v][13:12];
      step(1);
      do_start();
      for (int b = 7; b >= 1; b--) do_bit(VEC[v][4+b]);
      check($sformatf("R8 vec%0d held mid-byte", v), prev);
      do_bit(VEC[v][4]);
      check($sformatf("R3 R4 R5 R6 vec%0d decode", v), VEC[v][3:0]);
      do_stop();
      check($sformatf("R8 vec%0d held after stop", v), VEC[v][3:0]);
      prev = VEC[v][3:0];
    end

    // R7: aborted address byte leaves decode alone
    conn_hi = 2'd0; conn_lo = 2'd0; step(1);
    do_start();
    for (int b = 0; b < 4; b++) do_bit(1'b1);
    do_stop();
    check("R7 stop abort keeps decode", prev);

    // R7: repeated start restarts the count
    do_start();
    for (int b = 0; b < 4; b++) do_bit(1'b0);
    scl = 1'b0; step(1); sda = 1'b1; step(1); scl = 1'b1; step(1);
    do_start();
    for (int b = 0; b < 7; b++) do_bit(1'b1);
    check("R7 restart count, held before eighth edge", prev);
    do_bit(1'b0);
    check("R7 decode after restarted byte", 4'b1000);
    do_stop();

    // R6: SDA-tied upper pin, SDA never leaves low during the byte
    conn_hi = 2'd3; conn_lo = 2'd1; step(1);
    do_start();
    for (int b = 0; b < 8; b++) do_bit(1'b0);
    check("R6 quiet SDA pin decodes low", 4'b1001);
    do_stop();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule